// File: doc/BRIEF.md
# Dual-Personality Parallel Host Bus Slave

This block lets an 8-bit microcontroller reach a 32-entry register file over a parallel bus. Two static mode pins pick one of four bus personalities. The first pin picks between an Intel-style bus and a Motorola-style bus. The Intel-style bus has separate active-low read and write strobes, an address latch enable and a ready output. The Motorola-style bus has an active-low data strobe with a read/write level, an address strobe and an acknowledge output. The second pin picks whether the address shares the data pins or arrives on its own address bus.

All bus strobes are asynchronous to the block clock. Each one passes through a two-flop synchronizer, and the block detects edges on the synchronized copies. A four-state machine tracks each access. In IDLE the machine waits for chip select. SEL means the chip is selected and the address is pending. XFER means a strobe is active. DONE means the transfer has finished and the machine is waiting for chip select to rise. The named transitions are:
- select: IDLE to SEL, when chip select goes low.
- strobe: SEL to XFER, when a strobe asserts.
- finish: XFER to DONE, when the strobe releases while chip select is still low.
- abort: SEL or XFER to IDLE, when chip select rises.
- release: DONE to IDLE, when chip select rises.

On finish, the block issues a one-cycle register write strobe or register read strobe. The block never drives a shared bus itself. It provides the read data, a drive enable for the data pins, and a handshake level with its own drive enable.

Top module: `hostbus_slave`

## Requirements
- R1: `bus_intel`=1 selects Intel timing: `rdn_rw` is an active-low read strobe and `wrn_ds` is an active-low write strobe. `bus_intel`=0 selects Motorola timing: `wrn_ds` is an active-low data strobe and `rdn_rw`, sampled when the data strobe asserts, means read when 1 and write when 0.
- R2: With `bus_mux`=1, the register address is taken from `data_in[4:0]` when `addr_stb` falls while chip select is low. With `bus_mux`=0, it is taken from `addr_bus` when the strobe asserts.
- R3: In multiplexed mode, `data_in[7:5]` are ignored during address capture. An access at 0xE7 reaches register 0x07.
- R4: Every completed write produces exactly one `reg_we` pulse of one cycle. The pulse carries `reg_addr` and the data present on `data_in` while the strobe was active.
- R5: During a read, `data_oe` is 1 while the read strobe is active and `data_out` equals `reg_rdata` for the addressed register. `data_oe` returns to 0 after the strobe rises. A read produces one `reg_re` pulse and no `reg_we`.
- R6: In Intel mode, `hs_oe` is 0 while the bus is idle. Once chip select is recognised, the block drives `hs_out`=0. After the transfer completes, it drives `hs_out`=1. After chip select rises, `hs_oe` returns to 0.
- R7: In Motorola mode, `hs_oe` is always 1. `hs_out` goes to 1 once the address has been received. It goes to 0 when the transfer completes and stays 0 while the bus is idle.
- R8: If chip select rises before, or in the same cycle as, the strobe release, the access is dropped. No `reg_we` is issued and the register keeps its value.
- R9: After reset, `data_oe`=0, `reg_we`=0 and `reg_re`=0. The handshake is undriven in Intel mode and driven low in Motorola mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_intel | input | 1 | 1 = Intel timing, 0 = Motorola timing |
| bus_mux | input | 1 | 1 = address on data pins, 0 = separate address bus |
| cs_n | input | 1 | Active-low chip select |
| addr_stb | input | 1 | Address latch enable / address strobe; address captured on its fall |
| rdn_rw | input | 1 | Intel read strobe (active low) or Motorola read/write level |
| wrn_ds | input | 1 | Intel write strobe or Motorola data strobe (active low) |
| addr_bus | input | 5 | Separate address bus |
| data_in | input | 8 | Value seen on the data pins |
| data_out | output | 8 | Read data to drive onto the data pins |
| data_oe | output | 1 | Drive enable for the data pins |
| hs_out | output | 1 | Ready / acknowledge level |
| hs_oe | output | 1 | Drive enable for the handshake pin |
| reg_addr | output | 5 | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 8 | Register file read data for `reg_addr` |

## Verification
Chip-select release and strobe release can land in the same synchronized cycle. The machine must then decide between completing the write and aborting it. The bench provokes this by raising chip select and the write strobe on the same falling clock edge. Both pass through equal-depth synchronizers, so they reach the machine together. The bench then judges the outcome at the ports: the `reg_we` pulse count must not change, and a later read-back must return the earlier value. A second case raises chip select a few cycles before the strobe and is judged the same way.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEL  = 2'd1,
        ST_XFER = 2'd2,
        ST_DONE = 2'd3
    } hb_state_t;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
    import hb_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_intel,
    input  logic              bus_mux,
    input  logic              cs_s,
    input  logic              ale_s,
    input  logic              rd_s,
    input  logic              wr_s,
    input  logic [ADDR_W-1:0] addr_bus,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    output logic              data_oe,
    output logic              hs_out,
    output logic              hs_oe
);
    hb_state_t         state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              is_read_q;
    logic              addr_ok;
    logic              ale_d;
    logic              strobe_on;
    logic              read_req;
    logic              fire;

    // Intel: either active-low strobe; Motorola: data strobe only
    assign strobe_on = bus_intel ? (!rd_s || !wr_s) : !wr_s;
    assign read_req  = bus_intel ? !rd_s : rd_s;
    assign fire      = (state == ST_XFER) && !cs_s && !strobe_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (!cs_s) state_nx = ST_SEL;
            ST_SEL: begin
                if (cs_s)           state_nx = ST_IDLE;
                else if (strobe_on) state_nx = ST_XFER;
            end
            ST_XFER: begin
                if (cs_s)            state_nx = ST_IDLE;
                else if (!strobe_on) state_nx = ST_DONE;
            end
            ST_DONE: if (cs_s) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            is_read_q <= 1'b0;
            addr_ok   <= 1'b0;
            ale_d     <= 1'b0;
        end else begin
            ale_d <= ale_s;
            if (state == ST_IDLE) addr_ok <= 1'b0;
            if (bus_mux && !cs_s && ale_d && !ale_s) begin
                addr_q  <= data_in[ADDR_W-1:0];
                addr_ok <= 1'b1;
            end
            if (state == ST_SEL && !cs_s && strobe_on) begin
                is_read_q <= read_req;
                if (!bus_mux) begin
                    addr_q  <= addr_bus;
                    addr_ok <= 1'b1;
                end
            end
            if (state == ST_XFER) wdata_q <= data_in;
        end
    end

    always_comb begin
        reg_addr  = addr_q;
        reg_wdata = wdata_q;
        reg_we    = fire && !is_read_q;
        reg_re    = fire && is_read_q;
        data_oe   = (state == ST_XFER) && is_read_q;
        if (bus_intel) begin
            hs_oe  = (state != ST_IDLE);
            hs_out = (state == ST_DONE);
        end else begin
            hs_oe  = 1'b1;
            hs_out = addr_ok && (state == ST_SEL || state == ST_XFER);
        end
    end

    a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    a_r5_no_we_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !reg_we);
    a_r6_ready_released: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_intel && $rose(cs_s)) |=> !hs_oe);
    a_r7_ack_low_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_intel && $past(reg_we)) |-> !hs_out);
    a_r8_we_under_select: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !cs_s);
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave #(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_intel,
    input  logic              bus_mux,
    input  logic              cs_n,
    input  logic              addr_stb,
    input  logic              rdn_rw,
    input  logic              wrn_ds,
    input  logic [ADDR_W-1:0] addr_bus,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              hs_out,
    output logic              hs_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int NSIG = 4;
    localparam logic [NSIG-1:0] IDLE_LEVELS = 4'b1011; // cs_n, stb, rd, wr

    logic [NSIG-1:0] raw_v, sync_v;

    assign raw_v = {cs_n, addr_stb, rdn_rw, wrn_ds};

    hb_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVELS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_v),
        .q     (sync_v)
    );

    hb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_intel (bus_intel),
        .bus_mux   (bus_mux),
        .cs_s      (sync_v[3]),
        .ale_s     (sync_v[2]),
        .rd_s      (sync_v[1]),
        .wr_s      (sync_v[0]),
        .addr_bus  (addr_bus),
        .data_in   (data_in),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .data_oe   (data_oe),
        .hs_out    (hs_out),
        .hs_oe     (hs_oe)
    );

    assign data_out = reg_rdata;
endmodule

// File: tb/hostbus_slave_tb.sv
module hostbus_slave_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_intel = 1'b1, bus_mux = 1'b1;
    logic       cs_n = 1'b1, addr_stb = 1'b0, rdn_rw = 1'b1, wrn_ds = 1'b1;
    logic [4:0] addr_bus = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out, reg_wdata;
    logic [4:0] reg_addr;
    logic       data_oe, hs_out, hs_oe, reg_we, reg_re;
    logic [7:0] mem [32];
    logic [7:0] reg_rdata;
    int         n_checks = 0, n_errors = 0, we_cnt = 0, re_cnt = 0;

    always #4 clk = ~clk; // 125 MHz

    hostbus_slave u_dut (
        .clk(clk), .rst_n(rst_n), .bus_intel(bus_intel), .bus_mux(bus_mux),
        .cs_n(cs_n), .addr_stb(addr_stb), .rdn_rw(rdn_rw), .wrn_ds(wrn_ds),
        .addr_bus(addr_bus), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .hs_out(hs_out), .hs_oe(hs_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    // register file model
    assign reg_rdata = mem[reg_addr];
    always_ff @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (reg_re) re_cnt <= re_cnt + 1;
    end

    // {intel, mux, addr[7:0], data[7:0]}
    localparam logic [17:0] VEC [8] = '{
        {1'b1, 1'b1, 8'h03, 8'hA5},
        {1'b1, 1'b0, 8'h11, 8'h3C},
        {1'b0, 1'b1, 8'h1F, 8'h5A},
        {1'b0, 1'b0, 8'h0A, 8'hC3},
        {1'b1, 1'b1, 8'hE7, 8'h81},
        {1'b0, 1'b1, 8'h68, 8'h7E},
        {1'b1, 1'b0, 8'h00, 8'hFF},
        {1'b0, 1'b1, 8'hB4, 8'h12}
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic addr_phase(input logic [7:0] a);
        cs_n = 1'b0;
        wait_cyc(5);
        if (bus_intel) check(hs_oe && !hs_out, "R6 ready low after select", {hs_oe, hs_out}, 2'b10);
        if (bus_mux) begin
            data_in  = a;
            addr_stb = 1'b1;
            wait_cyc(4);
            addr_stb = 1'b0;
            wait_cyc(5);
            if (!bus_intel) check(hs_oe && hs_out, "R7 ack high after address", {hs_oe, hs_out}, 2'b11);
        end else begin
            addr_bus = a[4:0];
        end
    endtask

    // abort: 0 none, 1 cs rises with strobe release, 2 cs rises first
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input int abort);
        int we0;
        we0 = we_cnt;
        addr_phase(a);
        data_in = d;
        if (!bus_intel) rdn_rw = 1'b0;
        wrn_ds = 1'b0;
        wait_cyc(5);
        if (!bus_intel) check(hs_out, "R7 ack high during strobe", hs_out, 1);
        if (abort == 2) begin cs_n = 1'b1; wait_cyc(4); end
        if (abort == 1) cs_n = 1'b1;
        wrn_ds = 1'b1;
        wait_cyc(5);
        if (abort == 0) begin
            if (bus_intel) check(hs_oe && hs_out, "R6 ready high after transfer", {hs_oe, hs_out}, 2'b11);
            else           check(hs_oe && !hs_out, "R7 ack low after transfer", {hs_oe, hs_out}, 2'b10);
            check(we_cnt == we0 + 1, "R4 one write pulse", we_cnt - we0, 1);
        end else begin
            check(we_cnt == we0, "R8 aborted write issues no strobe", we_cnt - we0, 0);
        end
        cs_n = 1'b1;
        rdn_rw = 1'b1;
        wait_cyc(5);
        if (bus_intel) check(!hs_oe, "R6 ready undriven after deselect", hs_oe, 0);
        else           check(hs_oe && !hs_out, "R7 ack idle low", {hs_oe, hs_out}, 2'b10);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        int we0, re0;
        we0 = we_cnt;
        re0 = re_cnt;
        addr_phase(a);
        data_in = 8'h00;
        if (bus_intel) rdn_rw = 1'b0;
        else begin rdn_rw = 1'b1; wrn_ds = 1'b0; end
        wait_cyc(5);
        check(data_oe, "R5 data driven during read strobe", data_oe, 1);
        d = data_out;
        rdn_rw = 1'b1;
        wrn_ds = 1'b1;
        wait_cyc(5);
        check(!data_oe, "R5 data released after strobe", data_oe, 0);
        check(re_cnt == re0 + 1 && we_cnt == we0, "R5 one read pulse, no write",
              {re_cnt - re0, we_cnt - we0}, {32'd1, 32'd0});
        cs_n = 1'b1;
        wait_cyc(5);
    endtask

    initial begin
        #1_000_000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        for (int i = 0; i < 32; i++) mem[i] = 8'h00;
        wait_cyc(3);
        check(!data_oe && !reg_we && !reg_re && !hs_oe, "R9 reset outputs quiet (Intel)",
              {data_oe, reg_we, reg_re, hs_oe}, 0);
        rst_n = 1'b1;
        wait_cyc(3);
        bus_intel = 1'b0;
        wait_cyc(1);
        check(hs_oe && !hs_out, "R9 Motorola ack idle low", {hs_oe, hs_out}, 2'b10);

        // vector walk: write then read back in every personality (R1, R2)
        for (int i = 0; i < 8; i++) begin
            bus_intel = VEC[i][17];
            bus_mux   = VEC[i][16];
            wait_cyc(3);
            bus_write(VEC[i][15:8], VEC[i][7:0], 0);
            bus_read(VEC[i][15:8], rd);
            check(rd == VEC[i][7:0], "R1 R2 read-back matches write", rd, VEC[i][7:0]);
        end

        // R3: upper bits were ignored; 0xE7 landed in register 0x07
        bus_intel = 1'b1; bus_mux = 1'b0; wait_cyc(3);
        bus_read(8'h07, rd);
        check(rd == 8'h81, "R3 upper address bits ignored", rd, 8'h81);
        bus_intel = 1'b0; wait_cyc(3);
        bus_read(8'h14, rd);
        check(rd == 8'h12, "R3 0xB4 maps to register 0x14", rd, 8'h12);

        // R8: same-cycle deselect and strobe release, then deselect first
        bus_intel = 1'b1; bus_mux = 1'b1; wait_cyc(3);
        bus_write(8'h03, 8'h99, 1);
        bus_read(8'h03, rd);
        check(rd == 8'hA5, "R8 same-cycle abort keeps value", rd, 8'hA5);
        bus_intel = 1'b0; bus_mux = 1'b0; wait_cyc(3);
        bus_write(8'h0A, 8'h44, 2);
        bus_read(8'h0A, rd);
        check(rd == 8'hC3, "R8 early deselect keeps value", rd, 8'hC3);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule